// File: doc/BRIEF.md
# Burst Memory Slave with Five-Channel Handshake

This block is a memory-mapped slave that holds a small byte-addressable store and serves full AXI4 bursts. A master posts a write request (ID, start address, beat count, beat size, burst kind), then streams write data beats with per-byte enables. The block returns one write completion carrying the request's ID. Reads follow the same pattern: a read request is answered by a train of data beats. Each beat carries its own status, and the final beat is flagged.

Writes and reads are handled by two state machines that run side by side and share only the byte-lane store. The write machine walks WR_IDLE → WR_DATA (on request accept) → WR_RESP (on the data beat marked last) → WR_IDLE (on completion accept). The read machine walks RD_IDLE → RD_FETCH (on request accept) → RD_SEND (always, one cycle later). From RD_SEND it moves on when the beat is accepted: back to RD_FETCH for a further beat, or to RD_IDLE after the last one. Each machine holds one transaction at a time. Accesses beyond the store and the reserved burst kind are answered with an error status.

Top module: `axb_mem_slave`

## Requirements
- R1: After the synchronous active-low reset is released, the write and read request channels are ready, write data is not ready, and neither write completions nor read beats are valid.
- R2: A write beat updates exactly the byte lanes whose enable bit is 1 (bit n covers data bits 8n+7..8n). Lanes with enable 0 keep their old contents, as later reads show.
- R3: The length field L (8 bits) gives L+1 beats, with 0 giving 1 and 255 giving 256. A read returns L+1 beats with the last flag set only on the final one. A write produces exactly one completion, issued only after the data beat marked last is accepted.
- R4: The write completion ID equals the accepted write request ID, and every read beat ID equals the accepted read request ID.
- R5: Burst kind 00 (fixed) uses the start address for every beat.
- R6: Burst kind 10 (wrap) advances by the beat size and folds back to the start of the aligned region of (L+1) × beat-size bytes when it reaches its end.
- R7: Burst kind 01 (increment) with size code S (2^S bytes per beat) uses the start address for beat 0. Each later beat is at the start address rounded down to 2^S, plus its beat index times 2^S. A read beat returns the full data word holding that address.
- R8: A beat whose address is at or beyond the store size is an error: a read beat returns status 10 with all-zero data, and a write beat alters nothing (no aliasing onto low addresses) and makes the burst's completion status 10. Otherwise the status is 00, and no other code is produced.
- R9: Burst kind 11 is addressed like kind 01, its writes take effect, and every read beat and write completion of it carries status 10.
- R10: Write data is not accepted before the write request; a data beat presented first waits and is then taken after the request.
- R11: A read burst and a write burst in flight at the same time both complete correctly.
- R12: Once a write completion or read beat is valid, it stays valid with unchanged contents until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wreq_id | input | ID_W | Write request ID |
| wreq_addr | input | ADDR_W | Write start byte address |
| wreq_len | input | 8 | Write beats minus one |
| wreq_size | input | 3 | Write beat size code (2^code bytes) |
| wreq_kind | input | 2 | Write burst kind |
| wreq_valid | input | 1 | Write request valid |
| wreq_ready | output | 1 | Write request ready |
| wdat_data | input | DATA_W | Write beat data |
| wdat_strb | input | DATA_W/8 | Write byte enables |
| wdat_last | input | 1 | Final write beat |
| wdat_valid | input | 1 | Write beat valid |
| wdat_ready | output | 1 | Write beat ready |
| wrsp_id | output | ID_W | Write completion ID |
| wrsp_code | output | 2 | Write completion status |
| wrsp_valid | output | 1 | Write completion valid |
| wrsp_ready | input | 1 | Write completion ready |
| rreq_id | input | ID_W | Read request ID |
| rreq_addr | input | ADDR_W | Read start byte address |
| rreq_len | input | 8 | Read beats minus one |
| rreq_size | input | 3 | Read beat size code |
| rreq_kind | input | 2 | Read burst kind |
| rreq_valid | input | 1 | Read request valid |
| rreq_ready | output | 1 | Read request ready |
| rdat_id | output | ID_W | Read beat ID |
| rdat_data | output | DATA_W | Read beat data |
| rdat_code | output | 2 | Read beat status |
| rdat_last | output | 1 | Final read beat |
| rdat_valid | output | 1 | Read beat valid |
| rdat_ready | input | 1 | Read beat ready |

## Verification
The hardest situations to reach from the ports are a data beat that arrives before its write request, and a read train that overlaps a write burst while the master stalls the read beats and completions. The stimulus covers the first by holding a data beat on the bus for several cycles with no request and only then posting the request. It covers the second by forking a write and a read burst onto disjoint regions while a pseudo-random pattern gates both ready inputs. Aliasing is probed by writing just past the top of the store and then reading address zero. That shows whether the truncated word index reached the store.

// File: rtl/axb_pkg.sv
package axb_pkg;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    localparam logic [1:0] CODE_OK  = 2'b00;
    localparam logic [1:0] CODE_ERR = 2'b10;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_DATA = 2'd1,
        WR_RESP = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_FETCH = 2'd1,
        RD_SEND  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/axb_addr_step.sv
module axb_addr_step
    import axb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        size_code,
    input  logic [7:0]        len_m1,
    input  burst_e            kind,
    output logic [ADDR_W-1:0] next_addr
);

    logic [ADDR_W-1:0] beat_bytes;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] region_base;
    logic [ADDR_W-1:0] folded;

    always_comb begin
        beat_bytes  = ADDR_W'(1) << size_code;
        aligned     = cur_addr & ~(beat_bytes - ADDR_W'(1));
        stepped     = aligned + beat_bytes;
        span        = (ADDR_W'(len_m1) + ADDR_W'(1)) << size_code;
        span_mask   = span - ADDR_W'(1);
        region_base = cur_addr & ~span_mask;
        folded      = ((stepped & span_mask) == '0) ? region_base : stepped;
        unique case (kind)
            BURST_FIXED: next_addr = cur_addr;
            BURST_WRAP:  next_addr = folded;
            default:     next_addr = stepped;
        endcase
    end

endmodule

// File: rtl/axb_lane_mem.sv
module axb_lane_mem #(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 256
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [LANES-1:0]     wr_strb,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data
);

    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(MEM_WORDS);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [MEM_WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_strb[g]) begin
                cells[wr_idx] <= wr_data[8*g +: 8];
            end
        end

        assign rd_data[8*g +: 8] = cells[rd_idx];
    end

endmodule

// File: rtl/axb_wr_fsm.sv
module axb_wr_fsm
    import axb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int MEM_WORDS = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      wreq_id,
    input  logic [ADDR_W-1:0]    wreq_addr,
    input  logic [7:0]           wreq_len,
    input  logic [2:0]           wreq_size,
    input  logic [1:0]           wreq_kind,
    input  logic                 wreq_valid,
    output logic                 wreq_ready,
    input  logic [DATA_W-1:0]    wdat_data,
    input  logic [LANES-1:0]     wdat_strb,
    input  logic                 wdat_last,
    input  logic                 wdat_valid,
    output logic                 wdat_ready,
    output logic [ID_W-1:0]      wrsp_id,
    output logic [1:0]           wrsp_code,
    output logic                 wrsp_valid,
    input  logic                 wrsp_ready,
    output logic                 mem_we,
    output logic [IDX_W-1:0]     mem_idx,
    output logic [LANES-1:0]     mem_strb,
    output logic [DATA_W-1:0]    mem_wdata
);

    localparam int LANES     = DATA_W / 8;
    localparam int LANE_LSB  = $clog2(LANES);
    localparam int IDX_W     = $clog2(MEM_WORDS);
    localparam int MEM_BYTES = MEM_WORDS * LANES;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_BYTES);

    wr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic [2:0]        size_q;
    logic [7:0]        len_q;
    burst_e            kind_q;
    logic [ID_W-1:0]   id_q;
    logic              err_q;
    logic              in_range;
    logic              req_fire;
    logic              beat_fire;

    axb_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr  (addr_q),
        .size_code (size_q),
        .len_m1    (len_q),
        .kind      (kind_q),
        .next_addr (addr_nxt)
    );

    assign in_range  = ({1'b0, addr_q} < LIMIT);
    assign req_fire  = (state_q == WR_IDLE) && wreq_valid;
    assign beat_fire = (state_q == WR_DATA) && wdat_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (wreq_valid)               state_d = WR_DATA;
            WR_DATA: if (wdat_valid && wdat_last)  state_d = WR_RESP;
            WR_RESP: if (wrsp_ready)               state_d = WR_IDLE;
            default:                               state_d = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wreq_ready = 1'b0;
        wdat_ready = 1'b0;
        wrsp_valid = 1'b0;
        unique case (state_q)
            WR_IDLE: wreq_ready = 1'b1;
            WR_DATA: wdat_ready = 1'b1;
            WR_RESP: wrsp_valid = 1'b1;
            default: ;
        endcase
    end

    // burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= '0;
            len_q  <= '0;
            kind_q <= BURST_INCR;
            id_q   <= '0;
            err_q  <= 1'b0;
        end else if (req_fire) begin
            addr_q <= wreq_addr;
            size_q <= wreq_size;
            len_q  <= wreq_len;
            kind_q <= burst_e'(wreq_kind);
            id_q   <= wreq_id;
            err_q  <= (wreq_kind == BURST_RSVD);
        end else if (beat_fire) begin
            addr_q <= addr_nxt;
            err_q  <= err_q | ~in_range;
        end
    end

    assign wrsp_id   = id_q;
    assign wrsp_code = err_q ? CODE_ERR : CODE_OK;
    assign mem_we    = beat_fire && in_range;
    assign mem_idx   = addr_q[LANE_LSB +: IDX_W];
    assign mem_strb  = wdat_strb;
    assign mem_wdata = wdat_data;

endmodule

// File: rtl/axb_rd_fsm.sv
module axb_rd_fsm
    import axb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int MEM_WORDS = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      rreq_id,
    input  logic [ADDR_W-1:0]    rreq_addr,
    input  logic [7:0]           rreq_len,
    input  logic [2:0]           rreq_size,
    input  logic [1:0]           rreq_kind,
    input  logic                 rreq_valid,
    output logic                 rreq_ready,
    output logic [ID_W-1:0]      rdat_id,
    output logic [DATA_W-1:0]    rdat_data,
    output logic [1:0]           rdat_code,
    output logic                 rdat_last,
    output logic                 rdat_valid,
    input  logic                 rdat_ready,
    output logic [IDX_W-1:0]     mem_idx,
    input  logic [DATA_W-1:0]    mem_rdata
);

    localparam int LANES     = DATA_W / 8;
    localparam int LANE_LSB  = $clog2(LANES);
    localparam int IDX_W     = $clog2(MEM_WORDS);
    localparam int MEM_BYTES = MEM_WORDS * LANES;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_BYTES);

    rd_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic [2:0]        size_q;
    logic [7:0]        len_q;
    logic [7:0]        cnt_q;
    burst_e            kind_q;
    logic [ID_W-1:0]   id_q;
    logic              rsvd_q;
    logic [DATA_W-1:0] data_q;
    logic [1:0]        code_q;
    logic              last_q;
    logic              in_range;
    logic              req_fire;
    logic              beat_fire;

    axb_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr  (addr_q),
        .size_code (size_q),
        .len_m1    (len_q),
        .kind      (kind_q),
        .next_addr (addr_nxt)
    );

    assign in_range  = ({1'b0, addr_q} < LIMIT);
    assign req_fire  = (state_q == RD_IDLE) && rreq_valid;
    assign beat_fire = (state_q == RD_SEND) && rdat_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (rreq_valid) state_d = RD_FETCH;
            RD_FETCH: state_d = RD_SEND;
            RD_SEND:  if (rdat_ready) state_d = last_q ? RD_IDLE : RD_FETCH;
            default:  state_d = RD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rreq_ready = 1'b0;
        rdat_valid = 1'b0;
        unique case (state_q)
            RD_IDLE:  rreq_ready = 1'b1;
            RD_SEND:  rdat_valid = 1'b1;
            default:  ;
        endcase
    end

    // burst context and beat register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            kind_q <= BURST_INCR;
            id_q   <= '0;
            rsvd_q <= 1'b0;
            data_q <= '0;
            code_q <= CODE_OK;
            last_q <= 1'b0;
        end else begin
            if (req_fire) begin
                addr_q <= rreq_addr;
                size_q <= rreq_size;
                len_q  <= rreq_len;
                cnt_q  <= '0;
                kind_q <= burst_e'(rreq_kind);
                id_q   <= rreq_id;
                rsvd_q <= (rreq_kind == BURST_RSVD);
            end
            if (state_q == RD_FETCH) begin
                data_q <= in_range ? mem_rdata : '0;
                code_q <= (in_range && !rsvd_q) ? CODE_OK : CODE_ERR;
                last_q <= (cnt_q == len_q);
            end
            if (beat_fire && !last_q) begin
                addr_q <= addr_nxt;
                cnt_q  <= cnt_q + 8'd1;
            end
        end
    end

    assign rdat_id   = id_q;
    assign rdat_data = data_q;
    assign rdat_code = code_q;
    assign rdat_last = last_q;
    assign mem_idx   = addr_q[LANE_LSB +: IDX_W];

endmodule

// File: rtl/axb_mem_slave.sv
module axb_mem_slave #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int MEM_WORDS = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ID_W-1:0]         wreq_id,
    input  logic [ADDR_W-1:0]       wreq_addr,
    input  logic [7:0]              wreq_len,
    input  logic [2:0]              wreq_size,
    input  logic [1:0]              wreq_kind,
    input  logic                    wreq_valid,
    output logic                    wreq_ready,
    input  logic [DATA_W-1:0]       wdat_data,
    input  logic [DATA_W/8-1:0]     wdat_strb,
    input  logic                    wdat_last,
    input  logic                    wdat_valid,
    output logic                    wdat_ready,
    output logic [ID_W-1:0]         wrsp_id,
    output logic [1:0]              wrsp_code,
    output logic                    wrsp_valid,
    input  logic                    wrsp_ready,
    input  logic [ID_W-1:0]         rreq_id,
    input  logic [ADDR_W-1:0]       rreq_addr,
    input  logic [7:0]              rreq_len,
    input  logic [2:0]              rreq_size,
    input  logic [1:0]              rreq_kind,
    input  logic                    rreq_valid,
    output logic                    rreq_ready,
    output logic [ID_W-1:0]         rdat_id,
    output logic [DATA_W-1:0]       rdat_data,
    output logic [1:0]              rdat_code,
    output logic                    rdat_last,
    output logic                    rdat_valid,
    input  logic                    rdat_ready
);

    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(MEM_WORDS);

    logic              mem_we;
    logic [IDX_W-1:0]  mem_widx;
    logic [LANES-1:0]  mem_strb;
    logic [DATA_W-1:0] mem_wdata;
    logic [IDX_W-1:0]  mem_ridx;
    logic [DATA_W-1:0] mem_rdata;

    axb_wr_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MEM_WORDS(MEM_WORDS)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wreq_id    (wreq_id),
        .wreq_addr  (wreq_addr),
        .wreq_len   (wreq_len),
        .wreq_size  (wreq_size),
        .wreq_kind  (wreq_kind),
        .wreq_valid (wreq_valid),
        .wreq_ready (wreq_ready),
        .wdat_data  (wdat_data),
        .wdat_strb  (wdat_strb),
        .wdat_last  (wdat_last),
        .wdat_valid (wdat_valid),
        .wdat_ready (wdat_ready),
        .wrsp_id    (wrsp_id),
        .wrsp_code  (wrsp_code),
        .wrsp_valid (wrsp_valid),
        .wrsp_ready (wrsp_ready),
        .mem_we     (mem_we),
        .mem_idx    (mem_widx),
        .mem_strb   (mem_strb),
        .mem_wdata  (mem_wdata)
    );

    axb_rd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MEM_WORDS(MEM_WORDS)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rreq_id    (rreq_id),
        .rreq_addr  (rreq_addr),
        .rreq_len   (rreq_len),
        .rreq_size  (rreq_size),
        .rreq_kind  (rreq_kind),
        .rreq_valid (rreq_valid),
        .rreq_ready (rreq_ready),
        .rdat_id    (rdat_id),
        .rdat_data  (rdat_data),
        .rdat_code  (rdat_code),
        .rdat_last  (rdat_last),
        .rdat_valid (rdat_valid),
        .rdat_ready (rdat_ready),
        .mem_idx    (mem_ridx),
        .mem_rdata  (mem_rdata)
    );

    axb_lane_mem #(
        .DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)
    ) u_mem (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_idx  (mem_widx),
        .wr_strb (mem_strb),
        .wr_data (mem_wdata),
        .rd_idx  (mem_ridx),
        .rd_data (mem_rdata)
    );

endmodule

// File: rtl/axb_mem_slave_chk.sv
module axb_mem_slave_chk #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wreq_valid,
    input logic              wreq_ready,
    input logic              wdat_valid,
    input logic              wdat_ready,
    input logic              wdat_last,
    input logic [ID_W-1:0]   wrsp_id,
    input logic [1:0]        wrsp_code,
    input logic              wrsp_valid,
    input logic              wrsp_ready,
    input logic              rreq_valid,
    input logic              rreq_ready,
    input logic [ID_W-1:0]   rdat_id,
    input logic [DATA_W-1:0] rdat_data,
    input logic [1:0]        rdat_code,
    input logic              rdat_last,
    input logic              rdat_valid,
    input logic              rdat_ready
);

    logic w_open;
    logic r_open;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_open <= 1'b0;
            r_open <= 1'b0;
        end else begin
            if (wreq_valid && wreq_ready)      w_open <= 1'b1;
            else if (wrsp_valid && wrsp_ready) w_open <= 1'b0;
            if (rreq_valid && rreq_ready)                   r_open <= 1'b1;
            else if (rdat_valid && rdat_ready && rdat_last) r_open <= 1'b0;
        end
    end

    // R10
    wdat_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdat_ready |-> w_open);

    // R3
    wrsp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrsp_valid) |-> $past(wdat_valid && wdat_ready && wdat_last));

    // R3
    rdat_inside_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdat_valid |-> r_open);

    // R12
    wrsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsp_valid && !wrsp_ready) |=> (wrsp_valid && $stable(wrsp_id) && $stable(wrsp_code)));

    // R12
    rdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdat_valid && !rdat_ready) |=> (rdat_valid && $stable(rdat_data) && $stable(rdat_id)
                                         && $stable(rdat_code) && $stable(rdat_last)));

    // R8
    wrsp_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrsp_valid |-> (wrsp_code == 2'b00 || wrsp_code == 2'b10));

    // R8
    rdat_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdat_valid |-> (rdat_code == 2'b00 || rdat_code == 2'b10));

endmodule

bind axb_mem_slave axb_mem_slave_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/tb_axb_mem_slave.sv
module tb_axb_mem_slave;

    localparam int CLK_P   = 10;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int ID_W    = 4;
    localparam int MEM_B   = 1024;
    localparam int WD_CYC  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ID_W-1:0]   wreq_id = '0;
    logic [ADDR_W-1:0] wreq_addr = '0;
    logic [7:0]        wreq_len = '0;
    logic [2:0]        wreq_size = '0;
    logic [1:0]        wreq_kind = '0;
    logic              wreq_valid = 1'b0;
    logic              wreq_ready;
    logic [DATA_W-1:0] wdat_data = '0;
    logic [3:0]        wdat_strb = '0;
    logic              wdat_last = 1'b0;
    logic              wdat_valid = 1'b0;
    logic              wdat_ready;
    logic [ID_W-1:0]   wrsp_id;
    logic [1:0]        wrsp_code;
    logic              wrsp_valid;
    logic              wrsp_ready = 1'b1;
    logic [ID_W-1:0]   rreq_id = '0;
    logic [ADDR_W-1:0] rreq_addr = '0;
    logic [7:0]        rreq_len = '0;
    logic [2:0]        rreq_size = '0;
    logic [1:0]        rreq_kind = '0;
    logic              rreq_valid = 1'b0;
    logic              rreq_ready;
    logic [ID_W-1:0]   rdat_id;
    logic [DATA_W-1:0] rdat_data;
    logic [1:0]        rdat_code;
    logic              rdat_last;
    logic              rdat_valid;
    logic              rdat_ready = 1'b1;

    axb_mem_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MEM_WORDS(256)) dut (.*);

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
        logic [1:0]        code;
        logic              last;
    } rexp_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic [1:0]      code;
    } bexp_t;

    rexp_t r_q[$];
    string r_tag_q[$];
    bexp_t b_q[$];
    string b_tag_q[$];

    logic [7:0]  ref_mem [0:MEM_B-1];
    logic [31:0] wbuf_data [0:255];
    logic [3:0]  wbuf_strb [0:255];

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  bp_en  = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int beat_addr(int a, int sz, int ln, int kind, int i);
        int s;
        int span;
        int lo;
        s = 1 << sz;
        if (kind == 0) return a;
        if (kind == 2) begin
            span = s * (ln + 1);
            lo   = a - (a % span);
            return lo + ((a - lo) + i * s) % span;
        end
        if (i == 0) return a;
        return (a / s) * s + i * s;
    endfunction

    // ready pattern for backpressure (R12)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (bp_en) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                rdat_ready = lfsr[0] | lfsr[5];
                wrsp_ready = lfsr[3];
            end else begin
                rdat_ready = 1'b1;
                wrsp_ready = 1'b1;
            end
        end
    end

    // read beat monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rdat_valid && rdat_ready) begin
                if (r_q.size() == 0) begin
                    check(1'b0, "R3 unexpected read beat", 64'(rdat_data), 64'd0);
                end else begin
                    rexp_t e;
                    string t;
                    e = r_q.pop_front();
                    t = r_tag_q.pop_front();
                    check(rdat_data == e.data, {t, " data"}, 64'(rdat_data), 64'(e.data));
                    check(rdat_code == e.code, {t, " status"}, 64'(rdat_code), 64'(e.code));
                    check(rdat_last == e.last, {t, " R3 last flag"}, 64'(rdat_last), 64'(e.last));
                    check(rdat_id == e.id, {t, " R4 id"}, 64'(rdat_id), 64'(e.id));
                end
            end
        end
    end

    // write completion monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wrsp_valid && wrsp_ready) begin
                if (b_q.size() == 0) begin
                    check(1'b0, "R3 extra completion", 64'(wrsp_code), 64'd0);
                end else begin
                    bexp_t e;
                    string t;
                    e = b_q.pop_front();
                    t = b_tag_q.pop_front();
                    check(wrsp_code == e.code, {t, " completion status"}, 64'(wrsp_code), 64'(e.code));
                    check(wrsp_id == e.id, {t, " R4 completion id"}, 64'(wrsp_id), 64'(e.id));
                end
            end
        end
    end

    task automatic do_write(input int id, input int addr, input int len, input int sz,
                            input int kind, input bit early, input string tag);
        bit err;
        bexp_t be;
        err = (kind == 3);
        for (int i = 0; i <= len; i++) begin
            int ba;
            ba = beat_addr(addr, sz, len, kind, i);
            if (ba >= MEM_B) begin
                err = 1'b1;
            end else begin
                for (int l = 0; l < 4; l++)
                    if (wbuf_strb[i][l]) ref_mem[(ba / 4) * 4 + l] = wbuf_data[i][8*l +: 8];
            end
        end
        be.id   = ID_W'(id);
        be.code = err ? 2'b10 : 2'b00;
        b_q.push_back(be);
        b_tag_q.push_back(tag);
        if (early) begin
            @(posedge clk); #1;
            wdat_data  = wbuf_data[0];
            wdat_strb  = wbuf_strb[0];
            wdat_last  = (len == 0);
            wdat_valid = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(wdat_ready == 1'b0, "R10 data held before request", 64'(wdat_ready), 64'd0);
            end
        end
        @(posedge clk); #1;
        wreq_id    = ID_W'(id);
        wreq_addr  = ADDR_W'(addr);
        wreq_len   = 8'(len);
        wreq_size  = 3'(sz);
        wreq_kind  = 2'(kind);
        wreq_valid = 1'b1;
        do @(negedge clk); while (!wreq_ready);
        @(posedge clk); #1;
        wreq_valid = 1'b0;
        for (int i = 0; i <= len; i++) begin
            wdat_data  = wbuf_data[i];
            wdat_strb  = wbuf_strb[i];
            wdat_last  = (i == len);
            wdat_valid = 1'b1;
            do @(negedge clk); while (!wdat_ready);
            @(posedge clk); #1;
        end
        wdat_valid = 1'b0;
        wdat_last  = 1'b0;
        while (b_q.size() != 0) @(posedge clk);
    endtask

    task automatic do_read(input int id, input int addr, input int len, input int sz,
                           input int kind, input string tag);
        for (int i = 0; i <= len; i++) begin
            int ba;
            rexp_t e;
            ba = beat_addr(addr, sz, len, kind, i);
            e.id = ID_W'(id);
            if (ba < MEM_B) begin
                int w;
                w = (ba / 4) * 4;
                e.data = {ref_mem[w+3], ref_mem[w+2], ref_mem[w+1], ref_mem[w]};
                e.code = (kind == 3) ? 2'b10 : 2'b00;
            end else begin
                e.data = '0;
                e.code = 2'b10;
            end
            e.last = (i == len);
            r_q.push_back(e);
            r_tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        rreq_id    = ID_W'(id);
        rreq_addr  = ADDR_W'(addr);
        rreq_len   = 8'(len);
        rreq_size  = 3'(sz);
        rreq_kind  = 2'(kind);
        rreq_valid = 1'b1;
        do @(negedge clk); while (!rreq_ready);
        @(posedge clk); #1;
        rreq_valid = 1'b0;
        while (r_q.size() != 0) @(posedge clk);
    endtask

    task automatic fill_full(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            wbuf_data[i] = {8'(i + seed), 8'(~i), 8'(i ^ 8'h5A), 8'(seed * 3 + i * 7)};
            wbuf_strb[i] = 4'hF;
        end
    endtask

    // watchdog
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(wreq_ready == 1'b1, "R1 write request ready", 64'(wreq_ready), 64'd1);
        check(rreq_ready == 1'b1, "R1 read request ready", 64'(rreq_ready), 64'd1);
        check(wdat_ready == 1'b0, "R1 write data not ready", 64'(wdat_ready), 64'd0);
        check(wrsp_valid == 1'b0, "R1 no completion", 64'(wrsp_valid), 64'd0);
        check(rdat_valid == 1'b0, "R1 no read beat", 64'(rdat_valid), 64'd0);

        // R3: 256-beat fill of the whole store, read back under backpressure (R12)
        fill_full(256, 1);
        do_write(1, 0, 255, 2, 1, 1'b0, "R3 full write");
        bp_en = 1'b1;
        do_read(2, 0, 255, 2, 1, "R3 R12 full read");
        bp_en = 1'b0;

        // R3 single beat, R4 ids
        wbuf_data[0] = 32'hDEAD_BEEF; wbuf_strb[0] = 4'hF;
        do_write(3, 32'h020, 0, 2, 1, 1'b0, "R3 single write");
        do_read(14, 32'h020, 0, 2, 1, "R4 single read");

        // R2 partial strobes
        wbuf_data[0] = 32'h1122_3344; wbuf_strb[0] = 4'b0101;
        wbuf_data[1] = 32'h5566_7788; wbuf_strb[1] = 4'b1010;
        do_write(5, 32'h010, 1, 2, 1, 1'b0, "R2 strobe write");
        do_read(9, 32'h010, 1, 2, 1, "R2 strobe read");

        // R5 fixed bursts
        for (int i = 0; i < 4; i++) begin
            wbuf_data[i] = 32'h0101_0101 * (i + 2);
            wbuf_strb[i] = 4'(1 << i);
        end
        do_write(6, 32'h040, 3, 2, 0, 1'b0, "R5 fixed write");
        do_read(7, 32'h040, 2, 2, 0, "R5 fixed read");
        do_read(7, 32'h044, 0, 2, 1, "R5 neighbour untouched");

        // R6 wrap bursts
        fill_full(4, 40);
        do_write(8, 32'h0B8, 3, 2, 2, 1'b0, "R6 wrap write");
        do_read(10, 32'h0B0, 3, 2, 1, "R6 wrap placement");
        do_read(11, 32'h088, 3, 2, 2, "R6 wrap read 4");
        do_read(12, 32'h0D4, 7, 2, 2, "R6 wrap read 8");

        // R7 narrow and unaligned increments
        for (int i = 0; i < 4; i++) begin
            int ba;
            ba = beat_addr(32'h0A1, 0, 3, 1, i);
            wbuf_data[i] = {4{8'(8'hE0 + i)}};
            wbuf_strb[i] = 4'(1 << (ba % 4));
        end
        do_write(13, 32'h0A1, 3, 0, 1, 1'b0, "R7 byte write");
        do_read(13, 32'h0A0, 3, 1, 1, "R7 halfword read");
        do_read(4, 32'h0C2, 2, 2, 1, "R7 unaligned read");

        // R8 out of range, no aliasing onto address zero
        fill_full(2, 90);
        do_write(15, 32'h3FC, 1, 2, 1, 1'b0, "R8 edge write");
        do_read(15, 32'h3FC, 1, 2, 1, "R8 edge read");
        do_read(0, 32'h000, 0, 2, 1, "R8 no alias");

        // R9 reserved kind
        fill_full(2, 120);
        do_write(2, 32'h100, 1, 2, 3, 1'b0, "R9 reserved write");
        do_read(3, 32'h100, 1, 2, 3, "R9 reserved read");
        do_read(3, 32'h100, 1, 2, 1, "R9 reserved data stored");

        // R10 data beat before request
        fill_full(2, 150);
        do_write(9, 32'h120, 1, 2, 1, 1'b1, "R10 early data write");
        do_read(9, 32'h120, 1, 2, 1, "R10 early data read");

        // R11 overlapping read and write with backpressure (R12)
        fill_full(8, 200);
        bp_en = 1'b1;
        fork
            do_write(1, 32'h200, 7, 2, 1, 1'b0, "R11 R12 overlap write");
            do_read(6, 32'h300, 15, 2, 1, "R11 R12 overlap read");
        join
        bp_en = 1'b0;
        do_read(5, 32'h200, 7, 2, 1, "R11 overlap readback");

        repeat (5) @(posedge clk);
        check(r_q.size() == 0 && b_q.size() == 0, "R3 all responses seen",
              64'(r_q.size() + b_q.size()), 64'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule